// File: doc/BRIEF.md
# Powered-Device Port Power-Up Sequencer

This block follows the port voltage of a single-event (Type 1) Ethernet powered device as it moves through its power-up stages, and drives the enable for each stage. An external converter delivers port-voltage samples in millivolts with a valid strobe. A separate on-die sensor supplies a temperature in degrees Celsius. From these inputs the block decides four things: when the detection signature is presented, when the classification current sink is on and which class it draws, when the hotswap switch closes, and when a thermal fault forces the switch open.

Each voltage window is a parameter in millivolts. The hotswap enable follows a hysteretic lockout with separate rise and fall thresholds. The classification sink fires at most once between two classification resets, and it needs a detection since the port last dropped out. A one-hot phase output reports the current stage.

Top module: `poe_pd_sequencer`

## Requirements
- R1: After reset, phase is idle (5'b00001) and det_en, cls_en, hs_en are 0 and cls_code is 0.
- R2: det_en is 1, and phase is detect (5'b00010), exactly when the last valid sample lies in 1500..10100 mV inclusive and neither the powered nor the thermal-off phase applies.
- R3: cls_en is 1, and phase is classify (5'b00100), when the last valid sample lies in 14500..20500 mV inclusive, a detection was seen since the port was last below 1500 mV, and no classification has completed since the port was last below 2810 mV. Leaving that window ends cls_en.
- R4: While cls_en is 1, cls_code equals class_req. The encoding is 0: 0-4 mA, 1: 9-12 mA, 2: 17-20 mA, 3: 26-30 mA. While cls_en is 0, cls_code is 0.
- R5: Classification is single-event. Once the class window has been left, a return to the window does not re-enable cls_en until a sample below 2810 mV has been seen.
- R6: hs_en sets on a valid sample of 37000 mV or more. It clears only on a valid sample below 32000 mV. Samples in between keep it. Phase is powered (5'b01000) while hs_en is 1.
- R7: A jump from the detection window straight to 37000 mV or more powers the device without ever asserting cls_en.
- R8: temp_c of 160 or more forces hs_en to 0 and phase to thermal-off (5'b10000) on the next edge. The fault releases only when temp_c is below 140.
- R9: Phase is always one-hot. It changes on the clock edge after the sample or temperature that causes the change.
- R10: vsample_mv is ignored on cycles where vsample_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsample_valid | input | 1 | Sample strobe |
| vsample_mv | input | 16 | Port voltage in mV |
| class_req | input | 2 | Requested power class |
| temp_c | input | 8 | Die temperature in degrees C |
| det_en | output | 1 | Detection signature enable |
| cls_en | output | 1 | Classification current enable |
| cls_code | output | 2 | Class drawn while classifying |
| hs_en | output | 1 | Hotswap switch enable |
| phase | output | 5 | One-hot phase: idle, detect, classify, powered, thermal-off |

## Verification
The hardest state to reach is a return to the class window after classification has already completed. It is only meaningful when the port has passed through the window, left it upward and come back down without a classification reset. The stimulus drives exactly that walk: detect, classify, overshoot to 25 V, then back to 17 V. It then goes down to 2 V, which is inside the detection window but below the reset level, to show that classification re-arms. The thermal release band is covered the same way, by holding a powered port while the temperature steps to 160, then 145, then 139 degrees.

// File: rtl/poe_pd_sequencer.sv
module poe_pd_sequencer #(
  parameter int MVW          = 16,
  parameter int TW           = 8,
  parameter int DET_LO_MV    = 1500,
  parameter int DET_HI_MV    = 10100,
  parameter int CLS_ON_MV    = 14500,
  parameter int CLS_OFF_MV   = 20500,
  parameter int CLS_RST_MV   = 2810,
  parameter int LOCK_RISE_MV = 37000,
  parameter int LOCK_FALL_MV = 32000,
  parameter int HOT_C        = 160,
  parameter int HOT_HYST_C   = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vsample_valid,
  input  logic [MVW-1:0] vsample_mv,
  input  logic [1:0]     class_req,
  input  logic [TW-1:0]  temp_c,
  output logic           det_en,
  output logic           cls_en,
  output logic [1:0]     cls_code,
  output logic           hs_en,
  output logic [4:0]     phase
);
  localparam logic [MVW-1:0] DET_LO = MVW'(DET_LO_MV);
  localparam logic [MVW-1:0] DET_HI = MVW'(DET_HI_MV);
  localparam logic [MVW-1:0] CLS_ON = MVW'(CLS_ON_MV);
  localparam logic [MVW-1:0] CLS_OFF = MVW'(CLS_OFF_MV);
  localparam logic [MVW-1:0] CLS_RST = MVW'(CLS_RST_MV);
  localparam logic [MVW-1:0] RISE = MVW'(LOCK_RISE_MV);
  localparam logic [MVW-1:0] FALL = MVW'(LOCK_FALL_MV);
  localparam logic [TW-1:0]  T_SET = TW'(HOT_C);
  localparam logic [TW-1:0]  T_CLR = TW'(HOT_C - HOT_HYST_C);

  localparam logic [4:0] PH_IDLE = 5'b00001;
  localparam logic [4:0] PH_DET  = 5'b00010;
  localparam logic [4:0] PH_CLS  = 5'b00100;
  localparam logic [4:0] PH_PWR  = 5'b01000;
  localparam logic [4:0] PH_HOT  = 5'b10000;

  logic [MVW-1:0] v_q, vv;
  logic lock_q, hot_q, seen_q, done_q, code_set;
  logic lock_d, hot_d, seen_d, done_d;
  logic in_det, in_cls, below_rst;
  logic [4:0] phase_d;
  logic [1:0] code_q;

  assign vv        = vsample_valid ? vsample_mv : v_q;
  assign in_det    = (vv >= DET_LO) && (vv <= DET_HI);
  assign in_cls    = (vv >= CLS_ON) && (vv <= CLS_OFF);
  assign below_rst = vv < CLS_RST;

  assign lock_d = (vv >= RISE) ? 1'b1 : (vv < FALL) ? 1'b0 : lock_q;
  assign hot_d  = (temp_c >= T_SET) ? 1'b1 : (temp_c < T_CLR) ? 1'b0 : hot_q;
  assign seen_d = in_det ? 1'b1 : (vv < DET_LO) ? 1'b0 : seen_q;
  assign done_d = below_rst ? 1'b0 : (phase == PH_CLS && !in_cls) ? 1'b1 : done_q;

  always_comb begin
    if (hot_d)                              phase_d = PH_HOT;
    else if (lock_d)                        phase_d = PH_PWR;
    else if (in_det)                        phase_d = PH_DET;
    else if (in_cls && seen_q && !done_q)   phase_d = PH_CLS;
    else                                    phase_d = PH_IDLE;
  end

  assign code_set = (phase_d == PH_CLS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      lock_q <= 1'b0;
      hot_q  <= 1'b0;
      seen_q <= 1'b0;
      done_q <= 1'b0;
      phase  <= PH_IDLE;
      code_q <= 2'd0;
    end else begin
      v_q    <= vv;
      lock_q <= lock_d;
      hot_q  <= hot_d;
      seen_q <= seen_d;
      done_q <= done_d;
      phase  <= phase_d;
      code_q <= code_set ? class_req : 2'd0;
    end
  end

  assign det_en   = phase[1];
  assign cls_en   = phase[2];
  assign hs_en    = phase[3];
  assign cls_code = code_q;

  a_r9_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(phase));
  a_r2_det_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    det_en |-> (v_q >= DET_LO && v_q <= DET_HI));
  a_r3_cls_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cls_en |-> (v_q >= CLS_ON && v_q <= CLS_OFF));
  a_r4_code_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_en |-> cls_code == 2'd0);
  a_r6_hs_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> v_q >= FALL);
  a_r8_hot_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_c >= T_SET) |=> !hs_en);
endmodule

// File: tb/poe_pd_sequencer_tb.sv
module poe_pd_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsample_valid = 1'b0;
  logic [15:0] vsample_mv = '0;
  logic [1:0] class_req = 2'd0;
  logic [7:0] temp_c = 8'd25;
  logic det_en, cls_en, hs_en;
  logic [1:0] cls_code;
  logic [4:0] phase;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  poe_pd_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .vsample_valid(vsample_valid),
    .vsample_mv(vsample_mv), .class_req(class_req), .temp_c(temp_c),
    .det_en(det_en), .cls_en(cls_en), .cls_code(cls_code),
    .hs_en(hs_en), .phase(phase)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int mv);
    @(negedge clk);
    vsample_valid = 1'b1;
    vsample_mv = 16'(mv);
    @(negedge clk);
    vsample_valid = 1'b0;
  endtask

  task automatic set_temp(input int t);
    @(negedge clk);
    temp_c = 8'(t);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(phase, 5'b00001, "R1 phase");
    chk({det_en, cls_en, hs_en}, 0, "R1 enables");
    chk(cls_code, 0, "R1 code");
  endtask

  task automatic t_detect;
    put(5000);
    chk(phase, 5'b00010, "R2 detect phase");
    chk(det_en, 1, "R2 det_en");
    put(12000);
    chk(det_en, 0, "R2 above window");
    put(1000);
    chk(phase, 5'b00001, "R2 below window idle");
  endtask

  task automatic t_classify;
    class_req = 2'd2;
    put(17000);
    chk(cls_en, 0, "R3 no class without detection");
    put(5000);
    put(17000);
    chk(phase, 5'b00100, "R3 classify phase");
    chk(cls_code, 2, "R4 code follows class_req");
    put(25000);
    chk(cls_en, 0, "R3 off above window");
    chk(cls_code, 0, "R4 code zero when off");
    put(17000);
    chk(cls_en, 0, "R5 no second event");
    put(2000);
    chk(phase, 5'b00010, "R5 reset level detect");
    class_req = 2'd3;
    put(17000);
    chk(cls_en, 1, "R5 re-armed after reset");
    chk(cls_code, 3, "R4 code 3");
  endtask

  task automatic t_ignore;
    @(negedge clk);
    vsample_mv = 16'd1000;
    @(negedge clk);
    @(negedge clk);
    chk(phase, 5'b00100, "R10 invalid sample ignored");
  endtask

  task automatic t_lockout;
    put(38000);
    chk(hs_en, 1, "R6 rise");
    chk(phase, 5'b01000, "R6 powered phase");
    put(33000);
    chk(hs_en, 1, "R6 hold 33V");
    put(32000);
    chk(hs_en, 1, "R6 hold at fall level");
    put(31000);
    chk(hs_en, 0, "R6 fall");
    chk(phase, 5'b00001, "R6 idle after fall");
    put(36000);
    chk(hs_en, 0, "R6 below rise");
  endtask

  task automatic t_skip;
    int saw_cls = 0;
    put(1000);
    put(5000);
    @(negedge clk);
    vsample_valid = 1'b1;
    vsample_mv = 16'd40000;
    @(negedge clk);
    vsample_valid = 1'b0;
    if (cls_en) saw_cls = 1;
    chk(saw_cls, 0, "R7 no classification");
    chk(hs_en, 1, "R7 powered");
  endtask

  task automatic t_thermal;
    set_temp(159);
    chk(hs_en, 1, "R8 below threshold");
    set_temp(160);
    chk(hs_en, 0, "R8 trip");
    chk(phase, 5'b10000, "R8 thermal phase");
    set_temp(145);
    chk(phase, 5'b10000, "R8 hold in hysteresis");
    set_temp(140);
    chk(hs_en, 0, "R8 hold at 140");
    set_temp(139);
    chk(hs_en, 1, "R8 release");
    chk(phase, 5'b01000, "R9 powered again");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_detect();
    t_classify();
    t_ignore();
    t_lockout();
    t_skip();
    t_thermal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule